// File: doc/BRIEF.md
# Burst Ready Generator for a Cache Tag Array

This block produces the active-low burst-ready indication that tells the processor a secondary-cache access can finish. It sits beside a tag store, which is not part of this block. The tag store supplies the raw tag-compare hit and the stored valid and write-through status bits for the address being looked up. The block decides readiness in the same cycle from the cache's own hit, from the stored status and from the processor's write/read direction. It also merges in a ready request from an external synchronous source. That request is captured on each rising clock edge.

Two status interpretations exist. In dedicated mode the valid bit qualifies the hit, and the write-through bit makes processor writes wait. In generic mode the status bits carry user data and do not affect readiness. The output pin is modelled as a value `rdy_n` plus an enable flag `rdy_drive` in place of a tristate driver.

Top module: `burst_ready_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the captured external request is cleared to inactive. After reset, with no qualified hit, `rdy_n` is 1.
- R2: `ext_rdy_n` is captured at each rising edge. When the captured value is 0, `rdy_n` is 0 during the whole following cycle, unless R5 or R10 applies.
- R3: When `hit_ready_en` is 1 and the hit is qualified, `rdy_n` is 0 whatever the captured external request is. A hit is qualified when `tag_hit` and `chip_sel` are 1, it is not invalidated under R7, and it is not blocked under R9.
- R4: When `hit_ready_en` is 0, a qualified hit alone does not assert readiness. Only the captured external request can then drive `rdy_n` to 0.
- R5: In dedicated mode (`status_generic` = 0), with `st_wthru` = 1 and `proc_write` = 1 (write), `rdy_n` is 1 regardless of the hit and of the external request.
- R6: In dedicated mode with `st_wthru` = 1 and `proc_write` = 0 (read), readiness is evaluated normally.
- R7: In dedicated mode with `st_valid` = 0, the tag is invalid and a hit does not count.
- R8: In generic mode (`status_generic` = 1), `st_valid` and `st_wthru` have no effect on `rdy_n`.
- R9: While `write_cycle` or `status_clear` is 1, the hit does not count.
- R10: `rdy_drive` is 1 exactly when `rdy_oe_n` is 0 and `chip_sel` is 1. While `rdy_drive` is 0, `rdy_n` is 1.
- R11: With `chip_sel` = 0, a tag hit never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the external request is captured on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tag_hit | input | 1 | Raw tag-compare hit from the tag store |
| st_valid | input | 1 | Stored valid bit at the current address |
| st_wthru | input | 1 | Stored write-through bit at the current address |
| proc_write | input | 1 | Processor direction: 1 is write, 0 is read |
| status_generic | input | 1 | Status interpretation: 0 is dedicated, 1 is generic |
| ext_rdy_n | input | 1 | External ready request, active low, synchronous |
| hit_ready_en | input | 1 | Lets a qualified hit assert ready regardless of the external request |
| rdy_oe_n | input | 1 | Output enable for burst-ready, active low |
| chip_sel | input | 1 | Chip select, active high |
| write_cycle | input | 1 | A tag or status write is being clocked this cycle |
| status_clear | input | 1 | The synchronous status reset is active this cycle |
| rdy_n | output | 1 | Burst-ready value, active low |
| rdy_drive | output | 1 | 1 when the burst-ready pin is driven, 0 for high impedance |

## Verification
The bench sweeps every combination of the ten combinational controls. It does this once with the captured external request active and once with it inactive, and compares `rdy_n` and `rdy_drive` against an arithmetic model. The sweep targets several ways a faulty design would misbehave:
- A design that lets the external request bypass the write-through block would assert ready on a write-through write.
- One that forgot the valid-bit qualification would answer an invalidated tag.
- One that ignored the write or status-clear cycle would report a stale hit.
- A design that qualified the hit in generic mode would wrongly gate ready on user status data.

Reset is checked with the external request held active. A design that captured during reset would assert ready in the first cycle after reset.

// File: rtl/brdy_pkg.sv
package brdy_pkg;

    typedef enum logic {
        STATUS_DEDICATED = 1'b0,
        STATUS_GENERIC   = 1'b1
    } status_mode_e;

    typedef struct packed {
        logic hit;
        logic valid;
        logic wthru;
    } tag_lookup_t;

    typedef struct packed {
        logic proc_write;
        logic chip_sel;
        logic write_cycle;
        logic status_clear;
    } access_ctl_t;

    // A hit is lost whenever the tag is invalid in dedicated mode,
    // the chip is not selected, or a write/status-clear is in flight.
    function automatic logic hit_counts(input tag_lookup_t tl,
                                        input access_ctl_t ac,
                                        input status_mode_e mode);
        logic invalid_tag;
        invalid_tag = (mode == STATUS_DEDICATED) && !tl.valid;
        return tl.hit && ac.chip_sel && !invalid_tag
               && !ac.write_cycle && !ac.status_clear;
    endfunction

    function automatic logic wthru_write(input tag_lookup_t tl,
                                         input access_ctl_t ac,
                                         input status_mode_e mode);
        return (mode == STATUS_DEDICATED) && tl.wthru && ac.proc_write;
    endfunction

endpackage

// File: rtl/brdy_ext_sampler.sv
module brdy_ext_sampler #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_n,
    output logic ext_q_n
);

    always_ff @(posedge clk) begin
        if (rst) ext_q_n <= IDLE_LEVEL;
        else     ext_q_n <= ext_n;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (ext_q_n == IDLE_LEVEL));

    // R2
    capture_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_n |=> !ext_q_n);

endmodule

// File: rtl/brdy_hit_qualifier.sv
module brdy_hit_qualifier
    import brdy_pkg::*;
(
    input  tag_lookup_t  lookup,
    input  access_ctl_t  ctl,
    input  status_mode_e mode,
    output logic         hit_ok,
    output logic         wt_block
);

    always_comb begin
        hit_ok   = hit_counts(lookup, ctl, mode);
        wt_block = wthru_write(lookup, ctl, mode);
    end

endmodule

// File: rtl/brdy_output_stage.sv
module brdy_output_stage (
    input  logic hit_ok,
    input  logic wt_block,
    input  logic hit_ready_en,
    input  logic ext_q_n,
    input  logic oe_n,
    input  logic chip_sel,
    output logic rdy_n,
    output logic rdy_drive
);

    logic ready_req;

    always_comb begin
        ready_req = !wt_block && ((hit_ready_en && hit_ok) || !ext_q_n);
        rdy_drive = !oe_n && chip_sel;
        rdy_n     = rdy_drive ? !ready_req : 1'b1;
    end

endmodule

// File: rtl/burst_ready_gen.sv
module burst_ready_gen
    import brdy_pkg::*;
#(
    parameter logic EXT_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic tag_hit,
    input  logic st_valid,
    input  logic st_wthru,
    input  logic proc_write,
    input  logic status_generic,
    input  logic ext_rdy_n,
    input  logic hit_ready_en,
    input  logic rdy_oe_n,
    input  logic chip_sel,
    input  logic write_cycle,
    input  logic status_clear,
    output logic rdy_n,
    output logic rdy_drive
);

    tag_lookup_t  lookup;
    access_ctl_t  ctl;
    status_mode_e mode;
    logic         ext_q_n;
    logic         hit_ok;
    logic         wt_block;

    always_comb begin
        lookup = '{hit: tag_hit, valid: st_valid, wthru: st_wthru};
        ctl    = '{proc_write: proc_write, chip_sel: chip_sel,
                   write_cycle: write_cycle, status_clear: status_clear};
        mode   = status_mode_e'(status_generic);
    end

    brdy_ext_sampler #(.IDLE_LEVEL(EXT_IDLE)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .ext_n   (ext_rdy_n),
        .ext_q_n (ext_q_n)
    );

    brdy_hit_qualifier u_qual (
        .lookup   (lookup),
        .ctl      (ctl),
        .mode     (mode),
        .hit_ok   (hit_ok),
        .wt_block (wt_block)
    );

    brdy_output_stage u_out (
        .hit_ready_en (hit_ready_en),
        .hit_ok       (hit_ok),
        .wt_block     (wt_block),
        .ext_q_n      (ext_q_n),
        .oe_n         (rdy_oe_n),
        .chip_sel     (chip_sel),
        .rdy_n        (rdy_n),
        .rdy_drive    (rdy_drive)
    );

    // R5
    wt_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!status_generic && st_wthru && proc_write) |-> rdy_n);

    // R10
    undriven_high_chk: assert property (@(posedge clk) disable iff (rst)
        !rdy_drive |-> rdy_n);

    // R10
    drive_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_drive |-> (chip_sel && !rdy_oe_n));

    // R3
    forced_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy_drive && hit_ready_en && tag_hit && (status_generic || (st_valid && !st_wthru))
         && !write_cycle && !status_clear) |-> !rdy_n);

    // R7
    invalid_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (!status_generic && !st_valid && ext_q_n) |-> rdy_n);

endmodule

// File: tb/tb_burst_ready_gen.sv
module tb_burst_ready_gen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tag_hit = 0, st_valid = 0, st_wthru = 0, proc_write = 0;
    logic status_generic = 0, ext_rdy_n = 1, hit_ready_en = 0, rdy_oe_n = 0;
    logic chip_sel = 1, write_cycle = 0, status_clear = 0;
    logic rdy_n, rdy_drive;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_ready_gen dut (
        .clk(clk), .rst(rst), .tag_hit(tag_hit), .st_valid(st_valid),
        .st_wthru(st_wthru), .proc_write(proc_write),
        .status_generic(status_generic), .ext_rdy_n(ext_rdy_n),
        .hit_ready_en(hit_ready_en), .rdy_oe_n(rdy_oe_n), .chip_sel(chip_sel),
        .write_cycle(write_cycle), .status_clear(status_clear),
        .rdy_n(rdy_n), .rdy_drive(rdy_drive)
    );

    task automatic check(input string req, input logic act_n, input logic act_d,
                         input logic exp_n, input logic exp_d);
        checks++;
        if (act_n !== exp_n || act_d !== exp_d) begin
            failures++;
            $display("FAIL %s rdy_n=%b rdy_drive=%b expected rdy_n=%b rdy_drive=%b",
                     req, act_n, act_d, exp_n, exp_d);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: external request held active during reset must not be captured
        ext_rdy_n = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        ext_rdy_n = 1;
        #2 check("R1", rdy_n, rdy_drive, 1'b1, 1'b1);

        // R2: single low sample asserts ready for exactly one cycle
        @(negedge clk) ext_rdy_n = 0;
        @(posedge clk); #1 ext_rdy_n = 1;
        #2 check("R2", rdy_n, rdy_drive, 1'b0, 1'b1);
        @(posedge clk); #3 check("R2", rdy_n, rdy_drive, 1'b1, 1'b1);

        // Exhaustive sweep: captured external value x 10 control bits
        for (int e = 0; e < 2; e++) begin
            for (int v = 0; v < 1024; v++) begin
                logic ded, wtb, qh, req, drv, en;
                string tag;
                @(negedge clk) ext_rdy_n = logic'(e);
                @(posedge clk); #1;
                {tag_hit, st_valid, st_wthru, proc_write, status_generic,
                 hit_ready_en, rdy_oe_n, chip_sel, write_cycle, status_clear} = 10'(v);
                ded = !status_generic;
                wtb = ded && st_wthru && proc_write;
                qh  = tag_hit && chip_sel && !(ded && !st_valid)
                      && !write_cycle && !status_clear;
                req = !wtb && ((hit_ready_en && qh) || (e == 0));
                drv = !rdy_oe_n && chip_sel;
                en  = drv ? !req : 1'b1;
                if (!drv)                                     tag = "R10";
                else if (wtb)                                 tag = "R5";
                else if (!chip_sel)                           tag = "R11";
                else if (tag_hit && (write_cycle || status_clear)) tag = "R9";
                else if (tag_hit && ded && !st_valid)         tag = "R7";
                else if (tag_hit && !ded)                     tag = "R8";
                else if (ded && st_wthru)                     tag = "R6";
                else if (tag_hit && !hit_ready_en)            tag = "R4";
                else if (qh)                                  tag = "R3";
                else                                          tag = "R2";
                #2 check(tag, rdy_n, rdy_drive, en, drv);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule